// File: doc/BRIEF.md
# Replayable Stream Packet Buffer

This block sits in the transmit path of a half-duplex Ethernet MAC and keeps the opening beats of a frame so they can be sent again. Beats enter on an AXI-Stream slave port, each carrying data and an end-of-frame mark. They leave on an AXI-Stream master port in the order they arrived. The first `BUF_SIZE` beats of each frame are kept in storage after they are sent. When a collision forces a retry, the MAC can restart the frame from its first beat.

When the output has sent every retained beat, the block stops and raises `waiting`. The MAC then gives one of two single-cycle commands. A replay command starts the retained beats over, and it may be given as many times as needed. A continue command releases the retained beats. If the frame is already complete, continue closes it and frees the buffer for the next frame. Otherwise the block runs as a plain synchronous FIFO of `DEPTH` entries until the frame's last beat leaves. One frame is held at a time, and all logic runs on one clock.

Top module: `replay_fifo`

## Requirements
- R1: While and just after reset, `outValid` is 0, `inReady` is 1 and `waiting` is 0.
- R2: Accepted beats leave on the output with the same data and end mark, in arrival order, and a beat may be sent before its frame is complete.
- R3: Before continue, no more than `BUF_SIZE` beats of a frame are accepted. `inReady` stays 0 once that many are stored, even if none of them has been sent.
- R4: `waiting` is 1 exactly while the block is not in FIFO mode, has no unsent beat, and has either `BUF_SIZE` beats stored or the frame's last beat stored.
- R5: A replay command while `waiting` is 1 resends the retained beats from the first one. The output is valid in the cycle after the command, and this can be repeated any number of times.
- R6: A continue command while `waiting` is 1, with the frame's last beat stored, ends the frame. In the next cycle `waiting` is 0 and `inReady` is 1 for a new frame.
- R7: A continue command while `waiting` is 1, with the frame still open, switches to FIFO mode. Occupancy is then limited by `DEPTH`, and a slot frees as each beat is sent.
- R8: Commands given while `waiting` is 0 have no effect. In particular, a replay in FIFO mode does not disturb the output order.
- R9: If replay and continue arrive in the same cycle while `waiting` is 1, the replay is performed and the continue is dropped.
- R10: After a frame's last beat is accepted, `inReady` stays 0 until that frame is released. Release happens on continue when not in FIFO mode, or when the last beat is sent in FIFO mode.
- R11: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData`/`outLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | DATA_W | Input beat data |
| inLast | input | 1 | Input beat ends the frame |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Input beat can be taken |
| outData | output | DATA_W | Output beat data |
| outLast | output | 1 | Output beat ends the frame |
| outValid | output | 1 | Output beat offered |
| outReady | input | 1 | Downstream takes the output beat |
| replayCmd | input | 1 | Single-cycle request to resend retained beats |
| contCmd | input | 1 | Single-cycle request to release retained beats |
| waiting | output | 1 | Retained beats all sent, a command is needed |

## Verification
The bench builds the block with `DATA_W` = 8, `BUF_SIZE` = 4 and `DEPTH` = 8. The retained window and the FIFO capacity are then small enough to be filled within a few cycles. This makes the frame shapes easy to reach: frames shorter than the window, frames longer than the window, and the case where FIFO mode fills all eight slots under back-pressure. The frames are 3, 10, 14 and 2 beats long. Between them they cover repeated replays, a replay given in FIFO mode, and replay and continue given together.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

  // Strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic push;    // write input beat at the write pointer
    logic pop;     // advance read pointer
    logic rewind;  // move read pointer back to the frame base
    logic commit;  // move frame base up to the write pointer
  } fifoStrobes_t;

  typedef enum logic {
    PH_HOLD = 1'b0,  // retaining frame start, replayable
    PH_FLOW = 1'b1   // released, plain FIFO until last beat leaves
  } fifoPhase_t;

endpackage

// File: rtl/replay_fifo_store.sv
module replay_fifo_store
  import replay_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              empty,
  output logic [PTR_W-1:0]  storedCnt,
  output logic [PTR_W-1:0]  level
);

  localparam logic [PTR_W-1:0] DEPTH_LIM = PTR_W'(DEPTH);

  logic [DATA_W:0]    mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr, basePtr;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr[IDX_W-1:0]] <= {inLast, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      basePtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.rewind)   rdPtr <= basePtr;
      else if (strb.pop) rdPtr <= rdPtr + 1'b1;
      if (strb.commit) basePtr <= wrPtr;
    end
  end

  assign {outLast, outData} = mem[rdPtr[IDX_W-1:0]];
  assign empty     = (rdPtr == wrPtr);
  assign storedCnt = wrPtr - basePtr;
  assign level     = wrPtr - rdPtr;

  // R7: a write never lands on an occupied slot
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (level < DEPTH_LIM));

  // R11: a pending beat is held while it is not taken
  assert_hold_output_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !strb.pop && !strb.rewind) |=> (!empty && $stable(outData) && $stable(outLast)));

endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int BUF_SIZE = 8,
  parameter int DEPTH    = 16,
  localparam int PTR_W   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  input  logic             replayCmd,
  input  logic             contCmd,
  input  logic             empty,
  input  logic             headLast,
  input  logic [PTR_W-1:0] storedCnt,
  input  logic [PTR_W-1:0] level,
  output logic             inReady,
  output logic             outValid,
  output logic             waiting,
  output fifoStrobes_t     strb
);

  localparam logic [PTR_W-1:0] KEEP_LIM  = PTR_W'(BUF_SIZE);
  localparam logic [PTR_W-1:0] DEPTH_LIM = PTR_W'(DEPTH);

  fifoPhase_t phase;
  logic       lastSeen;
  logic       doCont;
  logic       tailOut;

  always_comb begin
    if (lastSeen)              inReady = 1'b0;
    else if (phase == PH_HOLD) inReady = (storedCnt < KEEP_LIM);
    else                       inReady = (level < DEPTH_LIM);
  end

  assign outValid = !empty;
  assign waiting  = (phase == PH_HOLD) && empty && (lastSeen || storedCnt == KEEP_LIM);
  assign doCont   = waiting && contCmd && !replayCmd;
  assign tailOut  = (phase == PH_FLOW) && outValid && outReady && headLast;

  always_comb begin
    strb.push   = inValid && inReady;
    strb.pop    = outValid && outReady;
    strb.rewind = waiting && replayCmd;
    strb.commit = (doCont && lastSeen) || tailOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_HOLD;
      lastSeen <= 1'b0;
    end else begin
      if (doCont && !lastSeen) phase <= PH_FLOW;
      else if (tailOut)        phase <= PH_HOLD;
      if (strb.commit)                  lastSeen <= 1'b0;
      else if (strb.push && inLast)     lastSeen <= 1'b1;
    end
  end

  // R3: the retained window never grows past BUF_SIZE beats
  assert_keep_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HOLD) |-> (storedCnt <= KEEP_LIM));

  // R10: the end of a frame closes the input
  assert_frame_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && inLast) |=> !inReady);

  // R6: an accepted continue always leaves the waiting state
  assert_cont_leaves_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    doCont |=> !waiting);

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BUF_SIZE = 8,
  parameter int DEPTH    = 16,
  localparam int PTR_W   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outValid,
  input  logic              outReady,
  input  logic              replayCmd,
  input  logic              contCmd,
  output logic              waiting
);

  fifoStrobes_t     strb;
  logic             empty;
  logic [PTR_W-1:0] storedCnt;
  logic [PTR_W-1:0] level;

  replay_fifo_ctrl #(.BUF_SIZE(BUF_SIZE), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .replayCmd(replayCmd), .contCmd(contCmd),
    .empty(empty), .headLast(outLast),
    .storedCnt(storedCnt), .level(level),
    .inReady(inReady), .outValid(outValid), .waiting(waiting),
    .strb(strb)
  );

  replay_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inData(inData), .inLast(inLast),
    .outData(outData), .outLast(outLast),
    .empty(empty), .storedCnt(storedCnt), .level(level)
  );

  // R5: a replay from the waiting state brings a beat back on the output
  assert_replay_resume_R5: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && replayCmd) |=> outValid);

  // R11: an offered beat is not withdrawn
  assert_valid_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !replayCmd) |=> outValid);

endmodule

// File: tb/tb_replay_fifo.sv
module tb_replay_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int KEEP = 4;
  localparam int DEP  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0, inValid = 1'b0, inReady;
  logic [DW-1:0] outData;
  logic          outLast, outValid;
  logic          outReady = 1'b1;
  logic          replayCmd = 1'b0, contCmd = 1'b0;
  logic          waiting;

  int            checks = 0, failures = 0;
  int            acceptCnt = 0;
  int            histLen = 0;
  bit            drvBusy = 0;
  bit            finished = 0;
  string         curReq = "R2";
  logic [DW:0]   expQ[$];
  logic [DW:0]   hist[KEEP];

  replay_fifo #(.DATA_W(DW), .BUF_SIZE(KEEP), .DEPTH(DEP)) dut (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inLast(inLast), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outLast(outLast), .outValid(outValid), .outReady(outReady),
    .replayCmd(replayCmd), .contCmd(contCmd), .waiting(waiting)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: offers one frame, records expected beats as they are accepted.
  task automatic sendFrame(input int first, input int n);
    drvBusy = 1;
    histLen = (n < KEEP) ? n : KEEP;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = DW'(first + i);
      inLast  = (i == n - 1);
      #2;
      while (!inReady) begin
        @(negedge clk); #2;
      end
      expQ.push_back({inLast, inData});
      if (i < KEEP) hist[i] = {inLast, inData};
      acceptCnt++;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    drvBusy = 0;
  endtask

  task automatic pushReplay();
    for (int i = 0; i < histLen; i++) expQ.push_back(hist[i]);
  endtask

  // Called at a sample point; returns at the following negedge.
  task automatic issueCmd(input bit rep, input bit cont);
    replayCmd = rep;
    contCmd   = cont;
    @(negedge clk);
    replayCmd = 1'b0;
    contCmd   = 1'b0;
  endtask

  task automatic waitWaiting();
    do begin @(negedge clk); #2; end while (!waiting);
  endtask

  task automatic waitDrain();
    do begin @(negedge clk); #2; end while (expQ.size() != 0 || outValid || drvBusy);
  endtask

  // Monitor: pops the scoreboard on every output handshake.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, curReq, "unexpected output beat", int'({outLast, outData}), 0);
        end else begin
          logic [DW:0] e;
          e = expQ.pop_front();
          chk({outLast, outData} === e, curReq, "output beat {last,data}",
              int'({outLast, outData}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    #2;
    chk(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(inReady == 1'b1,  "R1", "inReady after reset", inReady, 1);
    chk(waiting == 1'b0,  "R1", "waiting after reset", waiting, 0);
    @(negedge clk);

    // Short frame: fully replayable, replayed twice, then closed (R2, R4, R5, R6, R10)
    curReq = "R2";
    sendFrame(8'h10, 3);
    waitWaiting();
    chk(outValid == 1'b0, "R4", "no pending beat while waiting", outValid, 0);
    chk(inReady == 1'b0,  "R10", "input closed after last beat", inReady, 0);
    chk(expQ.size() == 0, "R2", "all beats sent before waiting", expQ.size(), 0);
    curReq = "R5";
    pushReplay();
    issueCmd(1'b1, 1'b0);
    #2;
    chk(waiting == 1'b0, "R4", "waiting drops after replay", waiting, 0);
    chk(outValid == 1'b1, "R5", "replayed beat offered", outValid, 1);
    waitWaiting();
    pushReplay();
    issueCmd(1'b1, 1'b0);
    waitWaiting();
    chk(expQ.size() == 0, "R5", "second replay fully sent", expQ.size(), 0);
    issueCmd(1'b0, 1'b1);
    #2;
    chk(waiting == 1'b0, "R6", "waiting after closing continue", waiting, 0);
    chk(inReady == 1'b1, "R6", "input open for next frame", inReady, 1);
    chk(outValid == 1'b0, "R6", "nothing left to send", outValid, 0);
    @(negedge clk);

    // Long frame: window fills, one replay, then FIFO mode (R3, R7, R10)
    curReq = "R3";
    base = acceptCnt;
    fork sendFrame(8'h40, 10); join_none
    waitWaiting();
    chk(inReady == 1'b0, "R3", "input closed at full window", inReady, 0);
    chk(acceptCnt - base == KEEP, "R3", "beats taken before continue", acceptCnt - base, KEEP);
    pushReplay();
    issueCmd(1'b1, 1'b0);
    waitWaiting();
    curReq = "R7";
    issueCmd(1'b0, 1'b1);
    waitDrain();
    chk(acceptCnt - base == 10, "R7", "whole long frame taken", acceptCnt - base, 10);
    chk(inReady == 1'b1, "R10", "input reopens after last beat sent", inReady, 1);
    chk(waiting == 1'b0, "R4", "not waiting after FIFO frame", waiting, 0);

    // Back-pressure: window full without sending, hold, FIFO fills DEPTH (R3, R11, R7, R8)
    @(negedge clk);
    outReady = 1'b0;
    curReq = "R11";
    base = acceptCnt;
    fork sendFrame(8'h80, 14); join_none
    repeat (8) @(negedge clk);
    #2;
    chk(acceptCnt - base == KEEP, "R3", "window limit under back-pressure", acceptCnt - base, KEEP);
    chk(inReady == 1'b0, "R3", "input closed with unsent window", inReady, 0);
    chk(waiting == 1'b0, "R4", "not waiting with unsent beats", waiting, 0);
    chk(outValid == 1'b1, "R11", "beat offered", outValid, 1);
    held = outData;
    @(negedge clk); #2;
    chk(outValid == 1'b1, "R11", "valid held without ready", outValid, 1);
    chk(outData == held, "R11", "data held without ready", outData, held);
    @(negedge clk);
    outReady = 1'b1;
    waitWaiting();
    @(negedge clk);
    outReady = 1'b0;
    #2;
    curReq = "R8";
    issueCmd(1'b0, 1'b1);
    #2;
    issueCmd(1'b1, 1'b0);
    repeat (14) @(negedge clk);
    #2;
    chk(acceptCnt - base == KEEP + DEP, "R7", "FIFO fills to DEPTH", acceptCnt - base, KEEP + DEP);
    chk(inReady == 1'b0, "R7", "input closed at DEPTH", inReady, 0);
    chk(waiting == 1'b0, "R8", "replay in FIFO mode has no wait", waiting, 0);
    @(negedge clk);
    outReady = 1'b1;
    waitDrain();
    chk(acceptCnt - base == 14, "R8", "frame completes in order", acceptCnt - base, 14);

    // Simultaneous commands: replay wins (R9)
    @(negedge clk);
    curReq = "R9";
    sendFrame(8'hC0, 2);
    waitWaiting();
    pushReplay();
    issueCmd(1'b1, 1'b1);
    #2;
    chk(outValid == 1'b1, "R9", "replay taken over continue", outValid, 1);
    chk(inReady == 1'b0, "R9", "frame not closed by dropped continue", inReady, 0);
    waitWaiting();
    issueCmd(1'b0, 1'b1);
    #2;
    chk(inReady == 1'b1, "R6", "frame closed by later continue", inReady, 1);
    chk(expQ.size() == 0, "R2", "scoreboard empty at end", expQ.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule